// File: doc/BRIEF.md
# ROM Integrity Check Controller

After each reset this block reads the whole content of an external ROM. It streams the message part of the ROM, in address order, to an external hash engine over a valid/ready handshake. It then reads the expected digest, which is stored in the top words of the same ROM. The digest the hash engine returns and the expected digest read from the ROM are each captured into a register and brought out on ports. Once both are present, the block compares them and reports done and good to the power manager.

A redundantly encoded select register decides who drives the ROM port. The checker owns the port while the check runs. After the check the port is handed to a simple bus read port. Any select value that is not one of the two legal codes raises a sticky fatal flag. The `sel_flip_i` input XORs a mask onto the stored select value, so that an upset of that register can be modelled.

Top module: `rom_chk_top`

## Requirements
- R1: After a synchronous active-low reset, `done_o`, `good_o`, `fatal_o`, `bus_ready_o` and `hash_valid_o` are low. The first ROM read issued is to address 0.
- R2: ROM words 0 to 55 are delivered to the hash engine in ascending address order, one word per handshake (`hash_valid_o` and `hash_ready_i` both high). `hash_last_o` is high only with word 55.
- R3: While `hash_valid_o` is high and `hash_ready_i` is low, the valid signal, `hash_data_o` and `hash_last_o` hold their values into the next cycle.
- R4: The expected digest is read from ROM addresses 56 to 63. The word at address 56+k appears on `exp_dig_o[32k+31:32k]`. The first `dig_valid_i` pulse after reset is captured onto `comp_dig_o`, and later pulses are ignored.
- R5: The computed digest is accepted whether it arrives before or after the expected-digest reads finish. `done_o` rises only once both digests are held.
- R6: `good_o` is high only when the two digests are equal. On a mismatch, `done_o` still rises and `good_o` stays low.
- R7: `done_o` and `good_o` stay at their values until the next reset.
- R8: The stored select is 4'b1010 for checker ownership and 4'b0101 for bus ownership. If the select after the `sel_flip_i` mask is any other value, `fatal_o` is set from the next cycle on. It clears only on reset, and while it is set it forces `good_o` and `bus_ready_o` low.
- R9: `bus_ready_o` stays low until `done_o` is set and the select has switched to the bus. A bus read accepted in one cycle returns `bus_rvalid_o` high in the next cycle, with the ROM word at `bus_addr_i` on `bus_rdata_o`. This includes requests held pending since before completion.
- R10: A reset in the middle of a check restarts it from address 0. After the next completed check, the digest registers hold that run's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_req_o | output | 1 | ROM read request |
| rom_addr_o | output | 6 | ROM read address |
| rom_rdata_i | input | 32 | ROM read data, one cycle after the request |
| hash_valid_o | output | 1 | Message word valid to the hash engine |
| hash_data_o | output | 32 | Message word |
| hash_last_o | output | 1 | Final message word marker |
| hash_ready_i | input | 1 | Hash engine accepts the word |
| dig_valid_i | input | 1 | Computed digest valid pulse |
| dig_i | input | 256 | Computed digest |
| exp_dig_o | output | 256 | Expected digest read from the ROM |
| comp_dig_o | output | 256 | Captured computed digest |
| done_o | output | 1 | Check finished |
| good_o | output | 1 | Digests matched |
| fatal_o | output | 1 | Select corruption seen |
| sel_flip_i | input | 4 | Upset mask XORed onto the stored select |
| bus_req_i | input | 1 | Bus read request |
| bus_addr_i | input | 6 | Bus read address |
| bus_ready_o | output | 1 | Bus read accepted this cycle if requested |
| bus_rvalid_o | output | 1 | Bus read data valid |
| bus_rdata_o | output | 32 | Bus read data |

## Verification
A wrong pointer or a skipped state in the sequencer shows up at the hash port on the next handshake, as a word out of order or a misplaced last marker. It also shows up at the end as a wrong word in `exp_dig_o`. A capture or compare flaw shows up one cycle after both digests are held, as `done_o`/`good_o` that disagree with the values on the two digest ports. A bad select state shows up within one cycle as `fatal_o`, as `bus_ready_o` rising before `done_o`, or as bus data taken from the wrong address one cycle after acceptance.

// File: rtl/rom_chk_pkg.sv
// Package: shared constants and types for the ROM integrity checker.
// Assumes a 4-bit redundantly encoded ownership select.
package rom_chk_pkg;

    localparam int SEL_W = 4;
    localparam logic [SEL_W-1:0] SEL_CHK = 4'b1010;
    localparam logic [SEL_W-1:0] SEL_BUS = 4'b0101;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_LATCH  = 3'd1,
        ST_SEND   = 3'd2,
        ST_EFETCH = 3'd3,
        ST_ESTORE = 3'd4,
        ST_WAIT   = 3'd5,
        ST_DONE   = 3'd6
    } seq_state_e;

endpackage

// File: rtl/rom_chk_seq.sv
// Module: rom_chk_seq
// Walks the ROM once after reset. Message words are fetched one at a time,
// latched, and offered to the hash engine until accepted. Digest words are
// then fetched and handed to the compare unit.
// Assumes ROM read data is valid exactly one cycle after a request.
module rom_chk_seq
    import rom_chk_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter int DIG_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              hash_valid_o,
    output logic [DATA_W-1:0] hash_data_o,
    output logic              hash_last_o,
    input  logic              hash_ready_i,
    output logic              exp_we_o,
    output logic [((DIG_WORDS > 1) ? $clog2(DIG_WORDS) : 1)-1:0] exp_idx_o,
    output logic [DATA_W-1:0] exp_word_o,
    output logic              exp_last_o
);

    localparam int DEPTH     = 1 << ADDR_W;
    localparam int MSG_WORDS = DEPTH - DIG_WORDS;
    localparam int IDX_W     = (DIG_WORDS > 1) ? $clog2(DIG_WORDS) : 1;
    localparam logic [ADDR_W-1:0] MSG_LAST = ADDR_W'(MSG_WORDS - 1);
    localparam logic [ADDR_W-1:0] MSG_BASE = ADDR_W'(MSG_WORDS);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [DATA_W-1:0] hold_q;
    logic [ADDR_W-1:0] dig_off;

    // Sequencing: fetch, latch, offer each message word, then read the digest words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            ptr_q   <= '0;
            hold_q  <= '0;
        end else begin
            case (state_q)
                ST_FETCH:  state_q <= ST_LATCH;
                ST_LATCH: begin
                    hold_q  <= rd_data_i;
                    state_q <= ST_SEND;
                end
                ST_SEND: begin
                    if (hash_ready_i) begin
                        ptr_q   <= ptr_q + 1'b1;
                        state_q <= (ptr_q == MSG_LAST) ? ST_EFETCH : ST_FETCH;
                    end
                end
                ST_EFETCH: state_q <= ST_ESTORE;
                ST_ESTORE: begin
                    ptr_q   <= ptr_q + 1'b1;
                    state_q <= (ptr_q == TOP_ADDR) ? ST_WAIT : ST_EFETCH;
                end
                ST_WAIT: begin
                    if (done_i) state_q <= ST_DONE;
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end

    // Output decode: read strobes, hash handshake and digest word writes.
    always_comb begin
        dig_off      = ptr_q - MSG_BASE;
        rd_req_o     = (state_q == ST_FETCH) || (state_q == ST_EFETCH);
        rd_addr_o    = ptr_q;
        hash_valid_o = (state_q == ST_SEND);
        hash_data_o  = hold_q;
        hash_last_o  = (state_q == ST_SEND) && (ptr_q == MSG_LAST);
        exp_we_o     = (state_q == ST_ESTORE);
        exp_idx_o    = IDX_W'(dig_off);
        exp_word_o   = rd_data_i;
        exp_last_o   = (state_q == ST_ESTORE) && (ptr_q == TOP_ADDR);
    end

endmodule

// File: rtl/rom_chk_cmp.sv
// Module: rom_chk_cmp
// Holds the expected and computed digests and compares them once both are
// present, whichever arrives first. Only the first computed digest pulse
// after reset is taken. The result is sticky until reset.
module rom_chk_cmp #(
    parameter int DATA_W    = 32,
    parameter int DIG_WORDS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        exp_we_i,
    input  logic [((DIG_WORDS > 1) ? $clog2(DIG_WORDS) : 1)-1:0] exp_idx_i,
    input  logic [DATA_W-1:0]           exp_word_i,
    input  logic                        exp_last_i,
    input  logic                        dig_valid_i,
    input  logic [DATA_W*DIG_WORDS-1:0] dig_i,
    output logic [DATA_W*DIG_WORDS-1:0] exp_dig_o,
    output logic [DATA_W*DIG_WORDS-1:0] comp_dig_o,
    output logic                        done_o,
    output logic                        good_o
);

    localparam int DIG_W = DATA_W * DIG_WORDS;

    logic [DIG_WORDS-1:0][DATA_W-1:0] exp_q;
    logic [DIG_W-1:0]                 comp_q;
    logic                             comp_have_q;
    logic                             exp_have_q;
    logic                             done_q;
    logic                             good_q;
    logic [DIG_WORDS-1:0]             word_eq;

    // Per-word equality so that the compare stays one word wide deep.
    for (genvar k = 0; k < DIG_WORDS; k++) begin : g_word_eq
        assign word_eq[k] = (comp_q[k*DATA_W +: DATA_W] == exp_q[k]);
    end

    // Capture both digests and settle the verdict once both are held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q       <= '0;
            comp_q      <= '0;
            comp_have_q <= 1'b0;
            exp_have_q  <= 1'b0;
            done_q      <= 1'b0;
            good_q      <= 1'b0;
        end else begin
            if (exp_we_i) exp_q[exp_idx_i] <= exp_word_i;
            if (exp_last_i) exp_have_q <= 1'b1;
            if (dig_valid_i && !comp_have_q) begin
                comp_q      <= dig_i;
                comp_have_q <= 1'b1;
            end
            if (comp_have_q && exp_have_q && !done_q) begin
                done_q <= 1'b1;
                good_q <= &word_eq;
            end
        end
    end

    assign exp_dig_o  = exp_q;
    assign comp_dig_o = comp_q;
    assign done_o     = done_q;
    assign good_o     = good_q;

endmodule

// File: rtl/rom_chk_mux.sv
// Module: rom_chk_mux
// Owns the redundantly encoded select of the ROM port. It steers the port to
// the checker or the bus, flags any illegal select as a sticky fatal error,
// and generates bus read valid. Assumes done_i is sticky.
module rom_chk_mux
    import rom_chk_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [SEL_W-1:0]  sel_flip_i,
    input  logic              chk_req_i,
    input  logic [ADDR_W-1:0] chk_addr_i,
    input  logic              bus_req_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    output logic              rom_req_o,
    output logic [ADDR_W-1:0] rom_addr_o,
    output logic              bus_ready_o,
    output logic              bus_rvalid_o,
    output logic              fatal_o
);

    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] sel_eff;
    logic             sel_ok;
    logic             fatal_q;
    logic             rvalid_q;
    logic             own_chk;
    logic             own_bus;

    // Ownership select: checker from reset, bus once the check is done.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= SEL_CHK;
        else if (done_i) sel_q <= SEL_BUS;
    end

    // Decode the select as seen after a possible upset.
    always_comb begin
        sel_eff = sel_q ^ sel_flip_i;
        own_chk = (sel_eff == SEL_CHK) && !fatal_q;
        own_bus = (sel_eff == SEL_BUS) && !fatal_q;
        sel_ok  = (sel_eff == SEL_CHK) || (sel_eff == SEL_BUS);
    end

    // Sticky fatal flag on any illegal select encoding.
    always_ff @(posedge clk) begin
        if (!rst_n)       fatal_q <= 1'b0;
        else if (!sel_ok) fatal_q <= 1'b1;
    end

    // Bus read data valid one cycle after an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) rvalid_q <= 1'b0;
        else        rvalid_q <= bus_req_i && own_bus;
    end

    // Port steering; an illegal select drives no request.
    always_comb begin
        rom_req_o  = 1'b0;
        rom_addr_o = chk_addr_i;
        if (own_chk) begin
            rom_req_o = chk_req_i;
        end else if (own_bus) begin
            rom_req_o  = bus_req_i;
            rom_addr_o = bus_addr_i;
        end
    end

    assign bus_ready_o  = own_bus;
    assign bus_rvalid_o = rvalid_q;
    assign fatal_o      = fatal_q;

endmodule

// File: rtl/rom_chk_top.sv
// Module: rom_chk_top
// ROM integrity check controller. It ties the sequencer, the digest compare
// and the ownership mux together. Assumes a single-cycle-latency ROM outside.
module rom_chk_top
    import rom_chk_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter int DIG_WORDS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic                        rom_req_o,
    output logic [ADDR_W-1:0]           rom_addr_o,
    input  logic [DATA_W-1:0]           rom_rdata_i,
    output logic                        hash_valid_o,
    output logic [DATA_W-1:0]           hash_data_o,
    output logic                        hash_last_o,
    input  logic                        hash_ready_i,
    input  logic                        dig_valid_i,
    input  logic [DATA_W*DIG_WORDS-1:0] dig_i,
    output logic [DATA_W*DIG_WORDS-1:0] exp_dig_o,
    output logic [DATA_W*DIG_WORDS-1:0] comp_dig_o,
    output logic                        done_o,
    output logic                        good_o,
    output logic                        fatal_o,
    input  logic [SEL_W-1:0]            sel_flip_i,
    input  logic                        bus_req_i,
    input  logic [ADDR_W-1:0]           bus_addr_i,
    output logic                        bus_ready_o,
    output logic                        bus_rvalid_o,
    output logic [DATA_W-1:0]           bus_rdata_o
);

    localparam int IDX_W = (DIG_WORDS > 1) ? $clog2(DIG_WORDS) : 1;

    logic              chk_req;
    logic [ADDR_W-1:0] chk_addr;
    logic              exp_we;
    logic [IDX_W-1:0]  exp_idx;
    logic [DATA_W-1:0] exp_word;
    logic              exp_last;
    logic              done_raw;
    logic              good_raw;
    logic              fatal_raw;

    rom_chk_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIG_WORDS(DIG_WORDS)
    ) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_i       (done_raw),
        .rd_req_o     (chk_req),
        .rd_addr_o    (chk_addr),
        .rd_data_i    (rom_rdata_i),
        .hash_valid_o (hash_valid_o),
        .hash_data_o  (hash_data_o),
        .hash_last_o  (hash_last_o),
        .hash_ready_i (hash_ready_i),
        .exp_we_o     (exp_we),
        .exp_idx_o    (exp_idx),
        .exp_word_o   (exp_word),
        .exp_last_o   (exp_last)
    );

    rom_chk_cmp #(
        .DATA_W(DATA_W), .DIG_WORDS(DIG_WORDS)
    ) i_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .exp_we_i    (exp_we),
        .exp_idx_i   (exp_idx),
        .exp_word_i  (exp_word),
        .exp_last_i  (exp_last),
        .dig_valid_i (dig_valid_i),
        .dig_i       (dig_i),
        .exp_dig_o   (exp_dig_o),
        .comp_dig_o  (comp_dig_o),
        .done_o      (done_raw),
        .good_o      (good_raw)
    );

    rom_chk_mux #(
        .ADDR_W(ADDR_W)
    ) i_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_i       (done_raw),
        .sel_flip_i   (sel_flip_i),
        .chk_req_i    (chk_req),
        .chk_addr_i   (chk_addr),
        .bus_req_i    (bus_req_i),
        .bus_addr_i   (bus_addr_i),
        .rom_req_o    (rom_req_o),
        .rom_addr_o   (rom_addr_o),
        .bus_ready_o  (bus_ready_o),
        .bus_rvalid_o (bus_rvalid_o),
        .fatal_o      (fatal_raw)
    );

    assign done_o      = done_raw;
    assign good_o      = good_raw && !fatal_raw;
    assign fatal_o     = fatal_raw;
    assign bus_rdata_o = rom_rdata_i;

endmodule

// File: rtl/rom_chk_props.sv
// Module: rom_chk_props
// Port-level properties of rom_chk_top, attached by bind below.
module rom_chk_props (
    input logic clk,
    input logic rst_n,
    input logic hash_valid_o,
    input logic [31:0] hash_data_o,
    input logic hash_last_o,
    input logic hash_ready_i,
    input logic done_o,
    input logic good_o,
    input logic fatal_o,
    input logic bus_req_i,
    input logic bus_ready_o,
    input logic bus_rvalid_o
);

    p_last_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hash_last_o |-> hash_valid_o);

    p_hash_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hash_valid_o && !hash_ready_i) |=>
            (hash_valid_o && $stable(hash_data_o) && $stable(hash_last_o)));

    p_no_hash_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !hash_valid_o);

    p_good_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        good_o |-> done_o);

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    p_fatal_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |=> fatal_o);

    p_fatal_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |-> (!good_o && !bus_ready_o));

    p_ready_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready_o |-> done_o);

    p_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i && bus_ready_o) |=> bus_rvalid_o);

endmodule

bind rom_chk_top rom_chk_props i_props (
    .clk          (clk),
    .rst_n        (rst_n),
    .hash_valid_o (hash_valid_o),
    .hash_data_o  (hash_data_o),
    .hash_last_o  (hash_last_o),
    .hash_ready_i (hash_ready_i),
    .done_o       (done_o),
    .good_o       (good_o),
    .fatal_o      (fatal_o),
    .bus_req_i    (bus_req_i),
    .bus_ready_o  (bus_ready_o),
    .bus_rvalid_o (bus_rvalid_o)
);

// File: tb/test_rom_chk_top.sv
module test_rom_chk_top;

    typedef struct packed {
        logic [7:0] seed;
        logic       late;
        logic       match;
        logic [2:0] stall;
        logic       exp_good;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{seed: 8'h11, late: 1'b0, match: 1'b1, stall: 3'd0, exp_good: 1'b1},
        '{seed: 8'h23, late: 1'b1, match: 1'b1, stall: 3'd1, exp_good: 1'b1},
        '{seed: 8'h35, late: 1'b0, match: 1'b0, stall: 3'd2, exp_good: 1'b0},
        '{seed: 8'h47, late: 1'b1, match: 1'b0, stall: 3'd0, exp_good: 1'b0},
        '{seed: 8'h59, late: 1'b1, match: 1'b1, stall: 3'd3, exp_good: 1'b1},
        '{seed: 8'h6B, late: 1'b0, match: 1'b1, stall: 3'd1, exp_good: 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rom_req_o;
    logic [5:0]   rom_addr_o;
    logic [31:0]  rom_rdata_i = '0;
    logic         hash_valid_o;
    logic [31:0]  hash_data_o;
    logic         hash_last_o;
    logic         hash_ready_i = 1'b1;
    logic         dig_valid_i = 1'b0;
    logic [255:0] dig_i = '0;
    logic [255:0] exp_dig_o;
    logic [255:0] comp_dig_o;
    logic         done_o, good_o, fatal_o;
    logic [3:0]   sel_flip_i = '0;
    logic         bus_req_i = 1'b0;
    logic [5:0]   bus_addr_i = '0;
    logic         bus_ready_o, bus_rvalid_o;
    logic [31:0]  bus_rdata_o;

    logic [31:0]  rom [0:63];
    int n_checks = 0;
    int n_fail = 0;
    logic cur_late = 1'b0;
    logic cur_match = 1'b1;
    logic [2:0] cur_stall = '0;

    // Hash-side model state
    int nwords, order_err, last_err, stall_err, wait_cnt, cyc, early_done_err, ready_err;
    logic dig_sent, prev_stall;
    logic [31:0] prev_data;
    logic prev_last;

    always #10 clk = ~clk;

    rom_chk_top i_rom_chk_top (
        .clk(clk), .rst_n(rst_n),
        .rom_req_o(rom_req_o), .rom_addr_o(rom_addr_o), .rom_rdata_i(rom_rdata_i),
        .hash_valid_o(hash_valid_o), .hash_data_o(hash_data_o),
        .hash_last_o(hash_last_o), .hash_ready_i(hash_ready_i),
        .dig_valid_i(dig_valid_i), .dig_i(dig_i),
        .exp_dig_o(exp_dig_o), .comp_dig_o(comp_dig_o),
        .done_o(done_o), .good_o(good_o), .fatal_o(fatal_o),
        .sel_flip_i(sel_flip_i), .bus_req_i(bus_req_i), .bus_addr_i(bus_addr_i),
        .bus_ready_o(bus_ready_o), .bus_rvalid_o(bus_rvalid_o), .bus_rdata_o(bus_rdata_o)
    );

    // ROM model: one cycle read latency
    always @(posedge clk) if (rom_req_o) rom_rdata_i <= rom[rom_addr_o];

    function automatic logic [255:0] exp_digest();
        logic [255:0] d;
        for (int k = 0; k < 8; k++) d[32*k +: 32] = rom[56 + k];
        return d;
    endfunction

    function automatic logic [255:0] sent_digest();
        return cur_match ? exp_digest() : (exp_digest() ^ (256'h1 << 100));
    endfunction

    task automatic load_rom(input logic [7:0] seed);
        for (int i = 0; i < 64; i++)
            rom[i] = ({24'h0, seed} * 32'h9E3779B9) ^ (i * 32'h01000193) ^ {seed, 24'(i)};
    endtask

    task automatic check(input logic cond, input string req,
                         input logic [255:0] act, input logic [255:0] expv);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Hash engine model and monitors, all at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            nwords = 0; order_err = 0; last_err = 0; stall_err = 0;
            wait_cnt = 0; cyc = 0; early_done_err = 0; ready_err = 0;
            dig_sent = 1'b0; prev_stall = 1'b0; dig_valid_i = 1'b0;
            hash_ready_i = 1'b1; prev_data = '0; prev_last = 1'b0;
        end else begin
            cyc++;
            if (prev_stall && (!hash_valid_o || hash_data_o != prev_data || hash_last_o != prev_last))
                stall_err++;
            hash_ready_i = (cur_stall == 0) || ((cyc % (cur_stall + 1)) != 0);
            if (hash_valid_o && hash_ready_i) begin
                if (nwords > 55 || hash_data_o != rom[nwords]) order_err++;
                if (hash_last_o != (nwords == 55)) last_err++;
                nwords++;
            end
            prev_stall = hash_valid_o && !hash_ready_i;
            prev_data  = hash_data_o;
            prev_last  = hash_last_o;
            if (done_o && !dig_sent) early_done_err++;
            if (bus_ready_o && !done_o) ready_err++;
            if (dig_sent) begin
                dig_valid_i = 1'b0;
                if (wait_cnt < 4) begin
                    wait_cnt++;
                    dig_valid_i = (wait_cnt == 3);
                    dig_i = ~sent_digest();
                end
            end else if (nwords == 56) begin
                wait_cnt++;
                if (wait_cnt == (cur_late ? 60 : 1)) begin
                    dig_valid_i = 1'b1;
                    dig_i = sent_digest();
                    dig_sent = 1'b1;
                    wait_cnt = 0;
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!done_o && !good_o && !fatal_o && !bus_ready_o && !hash_valid_o, "R1 reset state",
              {done_o, good_o, fatal_o, bus_ready_o, hash_valid_o}, 0);
        check(rom_req_o && rom_addr_o == 0, "R1 first read address",
              {rom_req_o, rom_addr_o}, {1'b1, 6'd0});
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 4000 && !done_o; i++) @(negedge clk);
    endtask

    task automatic bus_read(input logic [5:0] a, input string req);
        bus_addr_i = a;
        bus_req_i = 1'b1;
        for (int i = 0; i < 4000 && !bus_ready_o; i++) @(negedge clk);
        @(negedge clk);
        bus_req_i = 1'b0;
        check(bus_rvalid_o && bus_rdata_o == rom[a], req, {bus_rvalid_o, bus_rdata_o}, {1'b1, rom[a]});
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(negedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // Table of runs
        for (int v = 0; v < NVEC; v++) begin
            load_rom(VECS[v].seed);
            cur_late = VECS[v].late;
            cur_match = VECS[v].match;
            cur_stall = VECS[v].stall;
            do_reset();
            wait_done();
            check(done_o, "R5 done reached", done_o, 1);
            check(early_done_err == 0, "R5 done before digest", early_done_err, 0);
            check(nwords == 56 && order_err == 0 && last_err == 0, "R2 hash stream",
                  {nwords, order_err, last_err}, {32'd56, 64'd0});
            check(stall_err == 0, "R3 hold under stall", stall_err, 0);
            check(exp_dig_o == exp_digest(), "R4 expected digest", exp_dig_o, exp_digest());
            repeat (8) @(negedge clk);
            check(comp_dig_o == sent_digest(), "R4 computed digest first pulse only",
                  comp_dig_o, sent_digest());
            check(good_o == VECS[v].exp_good, "R6 verdict", good_o, VECS[v].exp_good);
            check(done_o && good_o == VECS[v].exp_good, "R7 sticky", {done_o, good_o},
                  {1'b1, VECS[v].exp_good});
            bus_read(6'd0, "R9 bus read word 0");
            bus_read(6'd63, "R9 bus read word 63");
            check(ready_err == 0, "R9 ready before done", ready_err, 0);
        end

        // Bus request pending across completion
        load_rom(8'h7D); cur_late = 1'b0; cur_match = 1'b1; cur_stall = 3'd0;
        do_reset();
        repeat (20) @(negedge clk);
        bus_read(6'd17, "R9 request pending across completion");
        check(ready_err == 0 && done_o && good_o, "R9 ready waits for done",
              {ready_err, done_o, good_o}, {32'd0, 2'b11});

        // Fatal during the check
        do_reset();
        repeat (30) @(negedge clk);
        sel_flip_i = 4'b0001;
        @(negedge clk);
        sel_flip_i = 4'b0000;
        check(fatal_o, "R8 fatal on bad select", fatal_o, 1);
        repeat (400) @(negedge clk);
        check(fatal_o && !good_o && !bus_ready_o, "R8 fatal sticky and blocking",
              {fatal_o, good_o, bus_ready_o}, 3'b100);

        // Fatal after a good check, then reset clears it
        do_reset();
        wait_done();
        repeat (4) @(negedge clk);
        check(good_o && bus_ready_o, "R6 good before upset", {good_o, bus_ready_o}, 2'b11);
        sel_flip_i = 4'b1000;
        @(negedge clk);
        sel_flip_i = 4'b0000;
        check(fatal_o && !good_o && !bus_ready_o, "R8 fatal after done",
              {fatal_o, good_o, bus_ready_o}, 3'b100);

        // Reset in mid-check, new content, full rerun
        load_rom(8'h91); cur_match = 1'b1;
        do_reset();
        repeat (50) @(negedge clk);
        load_rom(8'hA3); cur_late = 1'b1;
        do_reset();
        check(!fatal_o, "R1 reset clears fatal", fatal_o, 0);
        wait_done();
        repeat (4) @(negedge clk);
        check(order_err == 0 && nwords == 56, "R10 restart from address 0",
              {order_err, nwords}, {32'd0, 32'd56});
        check(exp_dig_o == exp_digest() && comp_dig_o == sent_digest() && good_o,
              "R10 digests of latest run", exp_dig_o, exp_digest());

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule